// File: doc/BRIEF.md
# Chain Frame Packer

This block turns high-level commands for a daisy-chained serial protocol into the exact byte stream that a most-significant-bit-first SPI master shifts out. Four commands exist: break the chain, join the next device synchronously, join it asynchronously, and write a block of data to an address. Commands enter on a valid/ready port together with an address and a byte length. The payload bytes of a data write arrive on a second valid/ready port. The frame bytes leave on a third valid/ready port. A running count of the bytes sent lets the host size its frame buffer.

A data write is sent as a header byte, then the address with the high byte first, then the payload. The header holds a fixed three-bit opcode above the word count minus one. Payload bytes are bit-reversed on the way through. Header and address bytes are not. Lengths that one frame cannot hold are rejected and produce no bytes. Lengths that are not whole words are cut down to whole words and flagged.

Back-pressure rules: the output holds its byte while `out_ready` is low. A payload byte is taken only in a cycle where the output takes its reversed copy, so `pay_ready` never rises unless `out_ready` is high. A command is taken only when the previous command has fully left, which keeps the output in acceptance order.

Top module: `chain_frame_packer`

## Requirements
- R1: A break command (`cmd_op` = 2'b00) produces exactly one output byte, 0x04.
- R2: A synchronous-join command (`cmd_op` = 2'b01) produces the single byte 0x06, and an asynchronous-join command (`cmd_op` = 2'b10) produces the single byte 0x05.
- R3: A data command (`cmd_op` = 2'b11) with an accepted length L starts with the header byte 0xE0 OR (floor(L/4) - 1).
- R4: The header is followed by `cmd_addr[15:8]` and then `cmd_addr[7:0]`, neither of them bit-reversed.
- R5: After the address, floor(L/4)*4 payload bytes are taken from the payload port in order, and each one is output with its bits reversed: output bit i equals input bit 7-i.
- R6: A data command with L below 4 or above 128 produces no output bytes and takes no payload. `len_err` is high in the cycle after acceptance, and the block is ready for a new command in that cycle.
- R7: A data command with L in 4..128 and L not a multiple of 4 is sent truncated to whole words, and `len_err` is high in the cycle after acceptance.
- R8: `len_err` stays low after a data command whose length is a multiple of 4 within 4..128, and after any non-data command.
- R9: `cmd_ready` is low from the acceptance of a command that produces bytes until its last byte has been taken, so frames leave in the order their commands were accepted and never interleave.
- R10: `out_count` is zero after reset and increases by one for each output byte taken (`out_valid` and `out_ready` both high), wrapping modulo 2^CNT_W.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle, provided the payload source also holds its byte.
- R12: During reset `out_valid`, `pay_ready` and `len_err` are low and `out_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| cmd_op | input | 2 | 00 break, 01 synchronous join, 10 asynchronous join, 11 data write |
| cmd_addr | input | 16 | Target address of a data write |
| cmd_len | input | 8 | Payload length of a data write, in bytes |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Payload byte taken |
| pay_data | input | 8 | Payload byte |
| out_valid | output | 1 | Frame byte offered |
| out_ready | input | 1 | Downstream takes the frame byte |
| out_data | output | 8 | Frame byte, sent most significant bit first |
| out_count | output | 16 | Running count of frame bytes taken |
| len_err | output | 1 | One-cycle flag for a rejected or truncated length |

## Verification
The hardest case to reach is a payload byte that sits on the payload port while the output is back-pressured. The reversed byte must then stay on `out_data`, and `pay_ready` must stay low until the output takes it. The stimulus reaches this by driving `out_ready` low at random at several stall rates, while a payload source with gaps of its own holds each offered byte. The header, address and payload bytes are then checked one by one against a model, and every length of interest appears among the commands: the rejection edges 3 and 129, the extremes 0 and 255, and truncated lengths at both ends of the range.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  typedef enum logic [1:0] {
    OP_BREAK = 2'b00,
    OP_SYNC  = 2'b01,
    OP_ASYNC = 2'b10,
    OP_DATA  = 2'b11
  } cfp_op_e;

  localparam logic [7:0] CODE_BREAK = 8'h04;
  localparam logic [7:0] CODE_SYNC  = 8'h06;
  localparam logic [7:0] CODE_ASYNC = 8'h05;
  localparam logic [7:0] HDR_BASE   = 8'hE0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SINGLE,
    ST_HDR,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_PAY
  } cfp_state_e;
endpackage

// File: rtl/cfp_cmd_decode.sv
module cfp_cmd_decode
  import cfp_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 128
) (
  input  logic [1:0]       op,
  input  logic [LEN_W-1:0] len,
  output logic             is_data,
  output logic             reject,
  output logic             trunc,
  output logic [7:0]       first_byte,
  output logic [LEN_W-1:0] nbytes
);
  localparam int WCNT_W = $clog2(MAX_LEN / 4);

  logic [LEN_W-3:0]  words;
  logic [WCNT_W-1:0] wm1;

  always_comb begin
    words   = len[LEN_W-1:2];
    wm1     = WCNT_W'(words - (LEN_W-2)'(1));
    nbytes  = {words, 2'b00};
    is_data = (op == OP_DATA);
    reject  = is_data && ((len < LEN_W'(MIN_LEN)) || (len > LEN_W'(MAX_LEN)));
    trunc   = is_data && !reject && (len[1:0] != 2'b00);
    unique case (op)
      OP_BREAK: first_byte = CODE_BREAK;
      OP_SYNC:  first_byte = CODE_SYNC;
      OP_ASYNC: first_byte = CODE_ASYNC;
      default:  first_byte = HDR_BASE | 8'(wm1);
    endcase
  end
endmodule

// File: rtl/cfp_bit_rev.sv
module cfp_bit_rev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/cfp_sequencer.sv
module cfp_sequencer
  import cfp_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              dec_is_data,
  input  logic              dec_reject,
  input  logic              dec_trunc,
  input  logic [7:0]        dec_first,
  input  logic [LEN_W-1:0]  dec_nbytes,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_rev,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              len_err
);
  cfp_state_e        state_q;
  logic [7:0]        first_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  remain_q;
  logic              cmd_fire;
  logic              out_fire;

  assign cmd_ready = (state_q == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign pay_ready = (state_q == ST_PAY) && out_ready;
  assign out_fire  = out_valid && out_ready;

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    unique case (state_q)
      ST_SINGLE, ST_HDR: begin
        out_valid = 1'b1;
        out_data  = first_q;
      end
      ST_ADDR_HI: begin
        out_valid = 1'b1;
        out_data  = addr_q[ADDR_W-1 -: 8];
      end
      ST_ADDR_LO: begin
        out_valid = 1'b1;
        out_data  = addr_q[7:0];
      end
      ST_PAY: begin
        out_valid = pay_valid;
        out_data  = pay_rev;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      first_q  <= 8'h00;
      addr_q   <= '0;
      remain_q <= '0;
      len_err  <= 1'b0;
    end else begin
      len_err <= cmd_fire && (dec_reject || dec_trunc);
      unique case (state_q)
        ST_IDLE: if (cmd_fire) begin
          first_q  <= dec_first;
          addr_q   <= cmd_addr;
          remain_q <= dec_nbytes;
          if (!dec_is_data)     state_q <= ST_SINGLE;
          else if (!dec_reject) state_q <= ST_HDR;
        end
        ST_SINGLE:  if (out_fire) state_q <= ST_IDLE;
        ST_HDR:     if (out_fire) state_q <= ST_ADDR_HI;
        ST_ADDR_HI: if (out_fire) state_q <= ST_ADDR_LO;
        ST_ADDR_LO: if (out_fire) state_q <= ST_PAY;
        ST_PAY: if (out_fire) begin
          remain_q <= remain_q - LEN_W'(1);
          if (remain_q == LEN_W'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  hdr_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_fire && dec_is_data && !dec_reject) |=> (out_valid && out_data[7:5] == 3'b111));

  // R6
  reject_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_fire && dec_reject) |=> (cmd_ready && !out_valid && len_err));

  // R11
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  pay_follows_out_chk: assert property (@(posedge clk) disable iff (rst)
    pay_ready |-> out_ready);

  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !cmd_ready);
endmodule

// File: rtl/cfp_byte_counter.sv
module cfp_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/chain_frame_packer.sv
module chain_frame_packer
  import cfp_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [CNT_W-1:0]  out_count,
  output logic              len_err
);
  logic             dec_is_data;
  logic             dec_reject;
  logic             dec_trunc;
  logic [7:0]       dec_first;
  logic [LEN_W-1:0] dec_nbytes;
  logic [7:0]       pay_rev;

  cfp_cmd_decode #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) i_decode (
    .op(cmd_op), .len(cmd_len), .is_data(dec_is_data), .reject(dec_reject),
    .trunc(dec_trunc), .first_byte(dec_first), .nbytes(dec_nbytes)
  );

  cfp_bit_rev #(.W(8)) i_rev (.din(pay_data), .dout(pay_rev));

  cfp_sequencer #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .dec_is_data(dec_is_data), .dec_reject(dec_reject),
    .dec_trunc(dec_trunc), .dec_first(dec_first), .dec_nbytes(dec_nbytes),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_rev(pay_rev),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .len_err(len_err)
  );

  cfp_byte_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .inc(out_valid && out_ready), .count(out_count)
  );

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (out_count == $past(out_count) + CNT_W'(1)));

  // R10
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_ready) |=> $stable(out_count));
endmodule

// File: tb/test_chain_frame_packer.sv
module test_chain_frame_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_addr = 16'h0;
  logic [7:0]  cmd_len = 8'h0;
  logic        pay_valid = 1'b0;
  logic        pay_ready;
  logic [7:0]  pay_data = 8'h0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic [15:0] out_count;
  logic        len_err;

  always #4 clk = ~clk;

  chain_frame_packer i_chain_frame_packer (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_count(out_count), .len_err(len_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int ready_pct = 75;
  int unsigned total_out = 0;
  bit run_done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] pay_q[$];

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // downstream ready with a variable stall rate
  initial forever begin
    @(negedge clk);
    out_ready = ($urandom % 100) < ready_pct;
  end

  // payload source: holds an offered byte until it is taken
  initial begin
    bit taken = 1'b0;
    forever begin
      @(negedge clk);
      if (taken) pay_valid = 1'b0;
      taken = 1'b0;
      if (!pay_valid && pay_q.size() > 0 && ($urandom % 3) != 0) begin
        pay_valid = 1'b1;
        pay_data  = pay_q[0];
      end
      #3;
      if (pay_valid && pay_ready) begin
        taken = 1'b1;
        void'(pay_q.pop_front());
      end
    end
  end

  // output monitor: byte compare and R11 hold check
  initial begin
    logic       p_stall = 1'b0;
    logic [7:0] p_data  = 8'h0;
    forever begin
      @(negedge clk);
      #3;
      if (!rst) begin
        if (p_stall) begin
          check("R11 valid held", 32'(out_valid), 32'd1);
          check("R11 data held", 32'(out_data), 32'(p_data));
        end
        if (out_valid && out_ready) begin
          total_out++;
          if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R6/R9 unexpected byte actual=%0h expected=none", out_data);
          end else begin
            check(tag_q.pop_front(), 32'(out_data), 32'(exp_q.pop_front()));
          end
        end
        p_stall = out_valid && !out_ready;
        p_data  = out_data;
      end
    end
  end

  task automatic do_cmd(input logic [1:0] op, input logic [15:0] addr, input logic [7:0] len);
    bit rej = 1'b0;
    bit trn = 1'b0;
    bit acc = 1'b0;
    int nb;
    case (op)
      2'b00: begin exp_q.push_back(8'h04); tag_q.push_back("R1 break"); end
      2'b01: begin exp_q.push_back(8'h06); tag_q.push_back("R2 sync"); end
      2'b10: begin exp_q.push_back(8'h05); tag_q.push_back("R2 async"); end
      default: begin
        rej = (len < 8'd4) || (len > 8'd128);
        if (!rej) begin
          trn = (len % 4) != 0;
          nb  = (len / 4) * 4;
          exp_q.push_back(8'hE0 | 8'((len / 4) - 1)); tag_q.push_back("R3 header");
          exp_q.push_back(addr[15:8]); tag_q.push_back("R4 addr hi");
          exp_q.push_back(addr[7:0]);  tag_q.push_back("R4 addr lo");
          for (int i = 0; i < nb; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            pay_q.push_back(d);
            exp_q.push_back(rev8(d));
            tag_q.push_back(trn ? "R7 truncated payload" : "R5 payload");
          end
        end
      end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_len = len;
    while (!acc) begin
      #3;
      acc = cmd_ready;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    cmd_op = 2'($urandom); cmd_len = 8'($urandom);
    #3;
    if (rej) begin
      check("R6 len_err", 32'(len_err), 32'd1);
      check("R6 ready again", 32'(cmd_ready), 32'd1);
      check("R6 no output", 32'(out_valid), 32'd0);
    end else if (trn) begin
      check("R7 len_err", 32'(len_err), 32'd1);
    end else begin
      check("R8 len_err low", 32'(len_err), 32'd0);
    end
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() == 0 && cmd_ready) break;
      if (exp_q.size() != 0) check("R9 busy", 32'(cmd_ready), 32'd0);
    end
    check("R10 count", 32'(out_count), 32'(total_out[15:0]));
    check("R5/R6 payload drained", 32'(pay_q.size()), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!run_done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    repeat (3) @(negedge clk);
    #3;
    check("R12 out_valid", 32'(out_valid), 32'd0);
    check("R12 pay_ready", 32'(pay_ready), 32'd0);
    check("R12 len_err", 32'(len_err), 32'd0);
    check("R12 out_count", 32'(out_count), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // directed corners
    do_cmd(2'b00, 16'h0000, 8'd0);
    do_cmd(2'b01, 16'h1234, 8'd9);
    do_cmd(2'b10, 16'hFFFF, 8'd200);
    do_cmd(2'b11, 16'hA55A, 8'd4);
    do_cmd(2'b11, 16'h0102, 8'd128);
    do_cmd(2'b11, 16'h0304, 8'd3);
    do_cmd(2'b11, 16'h0506, 8'd129);
    do_cmd(2'b11, 16'h0708, 8'd0);
    do_cmd(2'b11, 16'h090A, 8'd255);
    do_cmd(2'b11, 16'h0B0C, 8'd7);
    do_cmd(2'b11, 16'h0D0E, 8'd127);
    do_cmd(2'b11, 16'h0F10, 8'd5);
    ready_pct = 20;
    do_cmd(2'b11, 16'hBEEF, 8'd16);
    do_cmd(2'b00, 16'h0000, 8'd0);

    // constrained random at several stall rates
    for (int k = 0; k < 300; k++) begin
      logic [7:0] l;
      if (k % 50 == 0) ready_pct = 25 + int'($urandom % 76);
      l = ($urandom % 2) ? 8'($urandom % 140) : 8'(4 * (1 + $urandom % 32));
      do_cmd(2'($urandom), 16'($urandom), l);
    end

    run_done = 1'b1;
    summary();
    $finish;
  end
endmodule